// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible register file of a multi-channel DMA controller. A processor reaches it through a plain single-cycle bus made of a valid strobe, a write flag, a 12-bit byte address and 32-bit data. Each channel has its own bank of 64-bit source and destination addresses, a transfer size, a control word, a status word and a next-descriptor pointer. A global bank holds an enable bit, a summary of all channel flags, a per-channel interrupt-pending register and a per-channel interrupt mask.

The register file sends the programmed configuration of every channel to the channel engines, which sit outside this block. It takes back each engine's busy, paused, error-code and remaining-byte state, together with one-cycle completion and error pulses. It turns those pulses into sticky flags and drives one level-sensitive interrupt line.

Top module: `dmareg_regfile`

## Requirements
- R1: Channel c's bank starts at byte address c*0x100, for c below NCH (at most 8). Within a bank, the source address low and high words sit at 0x00 and 0x04, the destination address low and high words at 0x08 and 0x0C, the size at 0x10 and the next-descriptor pointer at 0x20. Each of these reads back the full 32 bits written. The configuration outputs give {high,low} as the 64-bit addresses.
- R2: The global enable sits at bit 0 of 0x800 and drives `glb_enable`. Its other bits read as zero. The interrupt mask at 0x80C keeps bits NCH-1:0 and reads zero above them.
- R3: The channel status word at offset 0x18 reads as follows: bit 0 engine busy, bit 1 complete flag, bit 2 error flag, bit 3 engine paused, bits 7:4 error code, bits 23:8 remaining bytes, and bits 31:24 zero.
- R4: A completion pulse sets the complete flag and an error pulse sets the error flag. Writing 1 to the flag's status bit clears it, and writing 0 leaves it unchanged.
- R5: When an engine pulse and a write-1-to-clear of the same flag fall in the same cycle, the flag stays set. This applies to the status flags and to the interrupt-pending bits.
- R6: Interrupt-pending bit c (0x808) is set by a completion or error pulse of channel c only while bit 1 of that channel's control word is 1. The bits are write-1-to-clear.
- R7: `irq` is high exactly when some interrupt-pending bit is set and its mask bit at 0x80C is 1.
- R8: Global status (0x804) reads bit 0 as the OR of all engine busy inputs, bit 1 as the OR of all complete flags, bit 2 as the OR of all error flags and bit 3 as the OR of all paused inputs. Bits 31:4 read as zero. Writes to it have no effect.
- R9: Control (offset 0x14) stores bits 13:0, and bits 31:14 read as zero. While the channel's engine is busy, a write changes only bit 0.
- R10: Unmapped offsets, and banks of channels at or above NCH, read as zero. Writes to them, and to read-only bits, change nothing.
- R11: After reset every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle, zero when not reading |
| eng_busy | input | NCH | Engine busy per channel |
| eng_paused | input | NCH | Engine paused per channel |
| eng_done | input | NCH | One-cycle completion pulse per channel |
| eng_err | input | NCH | One-cycle error pulse per channel |
| eng_code | input | 4*NCH | Error code per channel |
| eng_remain | input | 16*NCH | Remaining bytes per channel |
| cfg_src | output | 64*NCH | Source address per channel |
| cfg_dst | output | 64*NCH | Destination address per channel |
| cfg_size | output | 32*NCH | Transfer size per channel |
| cfg_ctrl | output | 32*NCH | Control word per channel |
| cfg_next | output | 32*NCH | Next-descriptor pointer per channel |
| glb_enable | output | 1 | Global enable bit |
| irq | output | 1 | Masked interrupt request |

## Verification
The risky overlap is a software write-1-to-clear landing in the same cycle as the engine pulse that sets the same bit. The bench provokes it by raising a completion pulse on the clock edge that also carries a status write of 0x02, and separately one that also carries an interrupt-pending write of that channel's bit. It then reads both registers back and expects the bit to be still set. A second overlap is a control write while the engine reports busy. That case is judged by reading back a word in which only the enable bit has moved.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int CTRL_W    = 14;
    localparam int CODE_W    = 4;
    localparam int REMAIN_W  = 16;
    localparam int CTRL_EN   = 0;
    localparam int CTRL_IE   = 1;

    localparam logic [7:0] OFF_SRC_LO = 8'h00;
    localparam logic [7:0] OFF_SRC_HI = 8'h04;
    localparam logic [7:0] OFF_DST_LO = 8'h08;
    localparam logic [7:0] OFF_DST_HI = 8'h0C;
    localparam logic [7:0] OFF_SIZE   = 8'h10;
    localparam logic [7:0] OFF_CTRL   = 8'h14;
    localparam logic [7:0] OFF_STAT   = 8'h18;
    localparam logic [7:0] OFF_NEXT   = 8'h20;

    localparam logic [ADDR_W-1:0] GLB_CTRL = 12'h800;
    localparam logic [ADDR_W-1:0] GLB_STAT = 12'h804;
    localparam logic [ADDR_W-1:0] GLB_IST  = 12'h808;
    localparam logic [ADDR_W-1:0] GLB_IEN  = 12'h80C;

    typedef struct packed {
        logic [WORD_W-1:0] src_lo;
        logic [WORD_W-1:0] src_hi;
        logic [WORD_W-1:0] dst_lo;
        logic [WORD_W-1:0] dst_hi;
        logic [WORD_W-1:0] size;
        logic [WORD_W-1:0] next;
        logic [CTRL_W-1:0] ctrl;
    } chan_cfg_t;

    typedef struct packed {
        logic                busy;
        logic                paused;
        logic                done;
        logic                err;
        logic [CODE_W-1:0]   code;
        logic [REMAIN_W-1:0] remain;
    } eng_stat_t;

    function automatic logic [WORD_W-1:0] pack_status(eng_stat_t s, logic cmp, logic errf);
        return {8'h00, s.remain, s.code, s.paused, errf, cmp, s.busy};
    endfunction

endpackage

// File: rtl/dmareg_chan.sv
module dmareg_chan
    import dmareg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        off,
    input  logic [WORD_W-1:0] wdata,
    input  eng_stat_t         eng,
    output chan_cfg_t         cfg,
    output logic              cmp_flag,
    output logic              err_flag,
    output logic              evt,
    output logic [WORD_W-1:0] rdata
);

    logic wr_stat;
    logic wr_ctrl;
    assign wr_stat = wr_en && (off == OFF_STAT);
    assign wr_ctrl = wr_en && (off == OFF_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            cmp_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (wr_en) begin
                case (off)
                    OFF_SRC_LO: cfg.src_lo <= wdata;
                    OFF_SRC_HI: cfg.src_hi <= wdata;
                    OFF_DST_LO: cfg.dst_lo <= wdata;
                    OFF_DST_HI: cfg.dst_hi <= wdata;
                    OFF_SIZE:   cfg.size   <= wdata;
                    OFF_NEXT:   cfg.next   <= wdata;
                    OFF_CTRL: begin
                        if (eng.busy) cfg.ctrl[CTRL_EN] <= wdata[CTRL_EN];
                        else          cfg.ctrl          <= wdata[CTRL_W-1:0];
                    end
                    default: ;
                endcase
            end
            if (eng.done)                 cmp_flag <= 1'b1;
            else if (wr_stat && wdata[1]) cmp_flag <= 1'b0;
            if (eng.err)                  err_flag <= 1'b1;
            else if (wr_stat && wdata[2]) err_flag <= 1'b0;
        end
    end

    assign evt = (eng.done || eng.err) && cfg.ctrl[CTRL_IE];

    always_comb begin
        case (off)
            OFF_SRC_LO: rdata = cfg.src_lo;
            OFF_SRC_HI: rdata = cfg.src_hi;
            OFF_DST_LO: rdata = cfg.dst_lo;
            OFF_DST_HI: rdata = cfg.dst_hi;
            OFF_SIZE:   rdata = cfg.size;
            OFF_NEXT:   rdata = cfg.next;
            OFF_CTRL:   rdata = {{(WORD_W-CTRL_W){1'b0}}, cfg.ctrl};
            OFF_STAT:   rdata = pack_status(eng, cmp_flag, err_flag);
            default:    rdata = '0;
        endcase
    end

    AST_CMP_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        eng.done |=> cmp_flag); // R5
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        eng.err |=> err_flag); // R5
    AST_CMP_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[1] && !eng.done) |=> !cmp_flag); // R4
    AST_CTRL_LOCK: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && eng.busy) |=> (cfg.ctrl[CTRL_W-1:1] == $past(cfg.ctrl[CTRL_W-1:1]))); // R9

endmodule

// File: rtl/dmareg_glob.sv
module dmareg_glob #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_ctrl,
    input  logic           wr_ist,
    input  logic           wr_ien,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] chan_evt,
    output logic           glb_en,
    output logic [NCH-1:0] ist,
    output logic [NCH-1:0] ien,
    output logic           irq
);

    logic [NCH-1:0] clr_mask;
    assign clr_mask = wr_ist ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en <= 1'b0;
            ist    <= '0;
            ien    <= '0;
        end else begin
            if (wr_ctrl) glb_en <= wdata[0];
            if (wr_ien)  ien    <= wdata;
            ist <= (ist & ~clr_mask) | chan_evt;
        end
    end

    assign irq = |(ist & ien);

    AST_IST_SET: assert property (@(posedge clk) disable iff (rst)
        (|chan_evt) |=> ((ist & $past(chan_evt)) == $past(chan_evt))); // R6
    AST_IST_W1C: assert property (@(posedge clk) disable iff (rst)
        (wr_ist && |(wdata & ~chan_evt)) |=> ((ist & $past(wdata & ~chan_evt)) == '0)); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ist == '0) |-> !irq); // R7

endmodule

// File: rtl/dmareg_regfile.sv
module dmareg_regfile
    import dmareg_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [NCH-1:0]         eng_busy,
    input  logic [NCH-1:0]         eng_paused,
    input  logic [NCH-1:0]         eng_done,
    input  logic [NCH-1:0]         eng_err,
    input  logic [NCH*CODE_W-1:0]  eng_code,
    input  logic [NCH*REMAIN_W-1:0] eng_remain,
    output logic [NCH*64-1:0]      cfg_src,
    output logic [NCH*64-1:0]      cfg_dst,
    output logic [NCH*32-1:0]      cfg_size,
    output logic [NCH*32-1:0]      cfg_ctrl,
    output logic [NCH*32-1:0]      cfg_next,
    output logic                   glb_enable,
    output logic                   irq
);

    localparam int SEL_W = 3;

    logic              is_chan;
    logic [SEL_W-1:0]  ch_idx;
    logic              wr_any;
    logic              rd_any;
    logic [NCH-1:0]    cmp_v, err_v, evt_v;
    logic [WORD_W-1:0] chan_rd [NCH];
    logic [NCH-1:0]    ist, ien;

    assign is_chan = !bus_addr[ADDR_W-1];
    assign ch_idx  = bus_addr[ADDR_W-2:ADDR_W-1-SEL_W];
    assign wr_any  = bus_valid && bus_write;
    assign rd_any  = bus_valid && !bus_write;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        eng_stat_t es;
        chan_cfg_t cf;
        assign es.busy   = eng_busy[c];
        assign es.paused = eng_paused[c];
        assign es.done   = eng_done[c];
        assign es.err    = eng_err[c];
        assign es.code   = eng_code[c*CODE_W +: CODE_W];
        assign es.remain = eng_remain[c*REMAIN_W +: REMAIN_W];

        dmareg_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_any && is_chan && (ch_idx == SEL_W'(c))),
            .off      (bus_addr[7:0]),
            .wdata    (bus_wdata),
            .eng      (es),
            .cfg      (cf),
            .cmp_flag (cmp_v[c]),
            .err_flag (err_v[c]),
            .evt      (evt_v[c]),
            .rdata    (chan_rd[c])
        );

        assign cfg_src [c*64 +: 64] = {cf.src_hi, cf.src_lo};
        assign cfg_dst [c*64 +: 64] = {cf.dst_hi, cf.dst_lo};
        assign cfg_size[c*32 +: 32] = cf.size;
        assign cfg_next[c*32 +: 32] = cf.next;
        assign cfg_ctrl[c*32 +: 32] = {{(32-CTRL_W){1'b0}}, cf.ctrl};
    end

    dmareg_glob #(.NCH(NCH)) u_glob (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_any && bus_addr == GLB_CTRL),
        .wr_ist   (wr_any && bus_addr == GLB_IST),
        .wr_ien   (wr_any && bus_addr == GLB_IEN),
        .wdata    (bus_wdata[NCH-1:0]),
        .chan_evt (evt_v),
        .glb_en   (glb_enable),
        .ist      (ist),
        .ien      (ien),
        .irq      (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_any) begin
            if (is_chan) begin
                for (int c = 0; c < NCH; c++) begin
                    if (ch_idx == SEL_W'(c)) bus_rdata = chan_rd[c];
                end
            end else begin
                case (bus_addr)
                    GLB_CTRL: bus_rdata = {31'b0, glb_enable};
                    GLB_STAT: bus_rdata = {28'b0, |eng_paused, |err_v, |cmp_v, |eng_busy};
                    GLB_IST:  bus_rdata = WORD_W'(ist);
                    GLB_IEN:  bus_rdata = WORD_W'(ien);
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    AST_CTRL_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_any && is_chan && bus_addr[7:0] == OFF_CTRL) |-> (bus_rdata[WORD_W-1:CTRL_W] == '0)); // R9
    AST_GLB_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_any && !is_chan && bus_addr > GLB_IEN) |-> (bus_rdata == '0)); // R10
    AST_STAT_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_any && is_chan && bus_addr[7:0] == OFF_STAT) |-> (bus_rdata[31:24] == 8'h00)); // R3

endmodule

// File: tb/dmareg_regfile_tb.sv
module dmareg_regfile_tb;

    localparam int NCH = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    eng_busy = '0, eng_paused = '0, eng_done = '0, eng_err = '0;
    logic [NCH*4-1:0]  eng_code = '0;
    logic [NCH*16-1:0] eng_remain = '0;
    logic [NCH*64-1:0] cfg_src, cfg_dst;
    logic [NCH*32-1:0] cfg_size, cfg_ctrl, cfg_next;
    logic              glb_enable, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dmareg_regfile #(.NCH(NCH)) u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_paused(eng_paused), .eng_done(eng_done),
        .eng_err(eng_err), .eng_code(eng_code), .eng_remain(eng_remain),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_size(cfg_size),
        .cfg_ctrl(cfg_ctrl), .cfg_next(cfg_next),
        .glb_enable(glb_enable), .irq(irq)
    );

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic pulse(int c, bit is_err);
        @(negedge clk);
        if (is_err) eng_err[c] = 1'b1; else eng_done[c] = 1'b1;
        @(negedge clk);
        eng_err = '0; eng_done = '0;
    endtask

    task automatic collide(int c, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        eng_done[c] = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; eng_done = '0;
    endtask

    task automatic t_reset();
        rd_chk("R11 ctrl", 12'h014, 32'h0);
        rd_chk("R11 ist", 12'h808, 32'h0);
        rd_chk("R11 src", 12'h300, 32'h0);
        check("R11 irq", irq, 1'b0);
    endtask

    task automatic t_map();
        wr(12'h200, 32'h1111_2222);
        wr(12'h204, 32'h3333_4444);
        wr(12'h308, 32'hA5A5_0001);
        wr(12'h30C, 32'h0000_00FF);
        wr(12'h110, 32'h0000_1000);
        wr(12'h020, 32'hDEAD_BEEF);
        rd_chk("R1 src lo", 12'h200, 32'h1111_2222);
        rd_chk("R1 src hi", 12'h204, 32'h3333_4444);
        rd_chk("R1 dst lo", 12'h308, 32'hA5A5_0001);
        rd_chk("R1 dst hi", 12'h30C, 32'h0000_00FF);
        rd_chk("R1 size", 12'h110, 32'h0000_1000);
        rd_chk("R1 next", 12'h020, 32'hDEAD_BEEF);
        check("R1 cfg_src", cfg_src[2*64 +: 64], 64'h3333_4444_1111_2222);
        check("R1 cfg_dst", cfg_dst[3*64 +: 64], 64'h0000_00FF_A5A5_0001);
        check("R1 cfg_size", cfg_size[32 +: 32], 32'h1000);
        check("R1 cfg_next", cfg_next[0 +: 32], 32'hDEAD_BEEF);
    endtask

    task automatic t_ctrl();
        wr(12'h114, 32'hFFFF_FFFF);
        rd_chk("R9 ctrl reserved", 12'h114, 32'h0000_3FFF);
        @(negedge clk) eng_busy[1] = 1'b1;
        wr(12'h114, 32'h0);
        rd_chk("R9 busy lock", 12'h114, 32'h0000_3FFE);
        check("R9 cfg_ctrl", cfg_ctrl[32 +: 32], 32'h3FFE);
        @(negedge clk) eng_busy[1] = 1'b0;
        wr(12'h114, 32'h2);
        rd_chk("R9 idle write", 12'h114, 32'h2);
    endtask

    task automatic t_status();
        @(negedge clk);
        eng_busy[0] = 1'b1; eng_paused[0] = 1'b1;
        eng_code[3:0] = 4'hA; eng_remain[15:0] = 16'h1234;
        rd_chk("R3 status layout", 12'h018, 32'h0012_34A9);
        rd_chk("R8 global busy/paused", 12'h804, 32'h9);
        wr(12'h018, 32'h0000_0001);
        rd_chk("R10 busy read-only", 12'h018, 32'h0012_34A9);
        @(negedge clk);
        eng_busy = '0; eng_paused = '0; eng_code = '0; eng_remain = '0;
    endtask

    task automatic t_w1c();
        pulse(0, 1'b0);
        rd_chk("R4 complete set", 12'h018, 32'h2);
        wr(12'h018, 32'h4);
        rd_chk("R4 other bit kept", 12'h018, 32'h2);
        wr(12'h018, 32'h0);
        rd_chk("R4 zero no effect", 12'h018, 32'h2);
        pulse(0, 1'b1);
        rd_chk("R4 error set", 12'h018, 32'h6);
        wr(12'h018, 32'h2);
        rd_chk("R4 clear complete", 12'h018, 32'h4);
        wr(12'h018, 32'h4);
        rd_chk("R4 clear error", 12'h018, 32'h0);
        rd_chk("R6 no ie no pending", 12'h808, 32'h0);
    endtask

    task automatic t_irq();
        pulse(1, 1'b0);
        rd_chk("R6 done pending", 12'h808, 32'h2);
        #1 check("R7 masked", irq, 1'b0);
        wr(12'h80C, 32'h2);
        #1 check("R7 unmasked", irq, 1'b1);
        wr(12'h214, 32'h2);
        pulse(2, 1'b1);
        rd_chk("R6 error pending", 12'h808, 32'h6);
        wr(12'h808, 32'h2);
        rd_chk("R6 w1c", 12'h808, 32'h4);
        #1 check("R7 after clear", irq, 1'b0);
        wr(12'h80C, 32'hFF);
        rd_chk("R2 mask width", 12'h80C, 32'hF);
        #1 check("R7 other bit", irq, 1'b1);
        wr(12'h808, 32'hF);
        #1 check("R7 all clear", irq, 1'b0);
        wr(12'h118, 32'h6);
        wr(12'h218, 32'h6);
    endtask

    task automatic t_collide();
        collide(2, 12'h218, 32'h2);
        rd_chk("R5 status set wins", 12'h218, 32'h2);
        wr(12'h808, 32'hF);
        collide(2, 12'h808, 32'h4);
        rd_chk("R5 pending set wins", 12'h808, 32'h4);
        wr(12'h808, 32'h4);
        rd_chk("R6 pending cleared", 12'h808, 32'h0);
    endtask

    task automatic t_global();
        wr(12'h800, 32'hFFFF_FFFF);
        rd_chk("R2 glb ctrl", 12'h800, 32'h1);
        check("R2 glb_enable", glb_enable, 1'b1);
        rd_chk("R8 complete or", 12'h804, 32'h2);
        wr(12'h218, 32'h2);
        rd_chk("R8 cleared", 12'h804, 32'h0);
        pulse(3, 1'b1);
        rd_chk("R8 error or", 12'h804, 32'h4);
        wr(12'h318, 32'h4);
        wr(12'h804, 32'hF);
        rd_chk("R8 write ignored", 12'h804, 32'h0);
    endtask

    task automatic t_unmapped();
        wr(12'h01C, 32'h5555_5555);
        rd_chk("R10 hole 0x1C", 12'h01C, 32'h0);
        rd_chk("R10 hole 0x24", 12'h024, 32'h0);
        wr(12'h400, 32'h1234);
        rd_chk("R10 bank beyond NCH", 12'h400, 32'h0);
        rd_chk("R10 ch0 untouched", 12'h000, 32'h0);
        rd_chk("R10 global hole", 12'h810, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_map();
        t_ctrl();
        t_status();
        t_w1c();
        t_irq();
        t_collide();
        t_global();
        t_unmapped();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule